// File: doc/BRIEF.md
# Wait-Edge and Timeout Interrupt Controller

This block raises interrupts for an asynchronous external-memory interface. It watches two kinds of event. The first is a rising edge on any of `NUM_WAIT` wait inputs, which arrive from off chip and are synchronized before use. The second is a one-cycle timeout pulse from the access sequencer. Each event sets its own raw pending flag, and each flag has its own enable bit.

Enables are never written directly. Software writes ones to a mask-set register or to a mask-clear register, so it can change one enable without first reading the others. Pending flags are cleared by writing ones to the status register. The single interrupt output is high while any enabled source is pending.

Register bit layout: bits `[NUM_WAIT-1:0]` belong to the wait inputs, in input order, and bit `NUM_WAIT` belongs to the timeout. Register addresses: 0 is mask-set, 1 is mask-clear, 2 is status, and 3 is unused.

Top module: `wirq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all enable bits and all pending bits are 0 and `irq` is low.
- R2: A write to address 0 sets every enable bit whose data bit is 1 on the next clock edge. Data bits that are 0 leave their enables unchanged.
- R3: A write to address 1 clears every enable bit whose data bit is 1 on the next clock edge. Data bits that are 0 leave their enables unchanged.
- R4: Reading address 0 and reading address 1 both return the current enable vector.
- R5: A 0-to-1 change on `wait_in[i]` sets pending bit i on the third rising clock edge after the change. The first two edges are synchronizer stages and the third registers the detected edge. An input held high does not set the bit again after it has been cleared.
- R6: A high `tmo_pulse` sets pending bit `NUM_WAIT` on the next clock edge.
- R7: Pending bits set on their events whether or not the matching enable is set.
- R8: A write to address 2 clears every pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged. Reading address 2 returns the pending vector.
- R9: If an event and a status clear reach the same pending bit in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when some bit is both pending and enabled. It follows register changes without any added cycle.
- R11: Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_in | input | NUM_WAIT | Asynchronous wait inputs |
| tmo_pulse | input | 1 | One-cycle access-timeout event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NUM_WAIT+1 | Register write data |
| reg_rdata | output | NUM_WAIT+1 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes and timeout pulses take effect one edge after they are applied. A wait-input rise takes effect on the third edge. Read data and `irq` follow the registers in the same cycle.

The bench drives inputs on falling edges. It samples results one falling edge after a write or timeout, and for wait inputs it holds each level for four cycles before sampling. One directed test samples after the second and after the third edge to check the exact three-edge delay. Another drives a timeout and a status clear in the same cycle to check the collision rule.

// File: rtl/wirq_pkg.sv
// Package: register address map shared by the controller and its bench.
// Assumes a 2-bit register address.
package wirq_pkg;
    typedef enum logic [1:0] {
        ADDR_MSET = 2'd0,
        ADDR_MCLR = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_RSVD = 2'd3
    } wirq_addr_e;
endpackage

// File: rtl/wirq_edge_sync.sv
// Synchronizes each asynchronous wait input through STAGES flops and emits
// a one-cycle pulse when the synchronized level goes from 0 to 1.
// Assumes STAGES >= 2 and that inputs stay stable for longer than a cycle.
module wirq_edge_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            logic              prev_q;

            // Shift the input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in[gi]};
            end

            // Remember the previous synchronized level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= chain_q[STAGES-1];
            end

            // A rise is a 1 now that was a 0 one cycle ago.
            always_comb rise[gi] = chain_q[STAGES-1] & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/wirq_mask_reg.sv
// Enable mask updated only by set and clear vectors. A clear takes
// precedence over a set on the same bit in the same cycle.
// Assumes set_vec and clr_vec are already qualified by the write decode.
module wirq_mask_reg #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] mask
);
    // Apply the sets first and then the clears, so that a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= (mask | set_vec) & ~clr_vec;
    end
endmodule

// File: rtl/wirq_pending.sv
// Raw pending flags: an event sets its flag and a write-one clears it.
// An event arriving in the same cycle as a clear keeps the flag set.
// Assumes each event is a single-cycle pulse.
module wirq_pending #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] event_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] pend
);
    // Clear first, then merge new events, so no event is lost.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | event_vec;
    end
endmodule

// File: rtl/wirq_ctrl.sv
// Top level of the wait-edge and timeout interrupt controller.
// Decodes register writes into mask set/clear and pending clear vectors,
// muxes read data, and combines pending and enabled sources into irq.
// Assumes tmo_pulse is synchronous to clk and wait_in is asynchronous.
module wirq_ctrl
    import wirq_pkg::*;
#(
    parameter int NUM_WAIT    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WAIT-1:0] wait_in,
    input  logic              tmo_pulse,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [NUM_WAIT:0] reg_wdata,
    output logic [NUM_WAIT:0] reg_rdata,
    output logic              irq
);
    localparam int SRC_W = NUM_WAIT + 1;

    logic [NUM_WAIT-1:0] wait_rise;
    logic [SRC_W-1:0]    event_vec;
    logic [SRC_W-1:0]    mset_vec;
    logic [SRC_W-1:0]    mclr_vec;
    logic [SRC_W-1:0]    pclr_vec;
    logic [SRC_W-1:0]    mask_q;
    logic [SRC_W-1:0]    pend_q;

    wirq_edge_sync #(
        .WIDTH  (NUM_WAIT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wait_in),
        .rise     (wait_rise)
    );

    // Put the timeout above the wait sources in the event vector.
    always_comb event_vec = {tmo_pulse, wait_rise};

    // Turn a write strobe into one-hot register write vectors.
    always_comb begin
        mset_vec = '0;
        mclr_vec = '0;
        pclr_vec = '0;
        if (reg_wr) begin
            unique case (wirq_addr_e'(reg_addr))
                ADDR_MSET: mset_vec = reg_wdata;
                ADDR_MCLR: mclr_vec = reg_wdata;
                ADDR_STAT: pclr_vec = reg_wdata;
                default:   ;
            endcase
        end
    end

    wirq_mask_reg #(.WIDTH(SRC_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (mset_vec),
        .clr_vec (mclr_vec),
        .mask    (mask_q)
    );

    wirq_pending #(.WIDTH(SRC_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_vec (event_vec),
        .clr_vec   (pclr_vec),
        .pend      (pend_q)
    );

    // Select read data by address; the unused address reads zero.
    always_comb begin
        unique case (wirq_addr_e'(reg_addr))
            ADDR_MSET, ADDR_MCLR: reg_rdata = mask_q;
            ADDR_STAT:            reg_rdata = pend_q;
            default:              reg_rdata = '0;
        endcase
    end

    // Raise irq for any source that is both pending and enabled.
    always_comb irq = |(pend_q & mask_q);
endmodule

// File: rtl/wirq_ctrl_chk.sv
// Checker for wirq_ctrl: properties on mask, pending and irq behaviour.
module wirq_ctrl_chk #(
    parameter int NUM_WAIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tmo_pulse,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [NUM_WAIT:0] reg_wdata,
    input logic              irq,
    input logic [NUM_WAIT:0] mask,
    input logic [NUM_WAIT:0] pend
);
    // R1: the first cycle after reset shows empty state.
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask == '0 && pend == '0 && !irq));

    // R2: bits written as ones to the set address end up enabled.
    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=> ((mask & $past(reg_wdata)) == $past(reg_wdata)));

    // R3: bits written as ones to the clear address end up disabled.
    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> ((mask & $past(reg_wdata)) == '0));

    // R2 and R3: without a mask write, the mask holds its value.
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == 2'd0 || reg_addr == 2'd1)) |=> $stable(mask));

    // R6: a timeout pulse sets the timeout pending bit.
    p_tmo_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> pend[NUM_WAIT]);

    // R8: a status clear with no timeout clears the timeout pending bit.
    p_stat_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && reg_wdata[NUM_WAIT] && !tmo_pulse) |=> !pend[NUM_WAIT]);

    // R10: irq is high only while some source is pending and enabled.
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend & mask) != '0));
endmodule

bind wirq_ctrl wirq_ctrl_chk #(.NUM_WAIT(NUM_WAIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmo_pulse (tmo_pulse),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .mask      (mask_q),
    .pend      (pend_q)
);

// File: tb/wirq_ctrl_tb.sv
`timescale 1ns/1ps
module wirq_ctrl_tb;
    localparam int NW = 4;
    localparam int W  = NW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] wait_in = '0;
    logic          tmo_pulse = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          irq;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wirq_ctrl #(.NUM_WAIT(NW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_in   (wait_in),
        .tmo_pulse (tmo_pulse),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Vector fields: op[19:18] (0 write, 1 wait pulse, 2 timeout),
    // addr[17:16], data[15:11], expected pending[10:6], mask[5:1], irq[0].
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 2'd0, 5'h01, 5'h00, 5'h01, 1'b0},  // R2 enable wait 0
        {2'd1, 2'd0, 5'h01, 5'h01, 5'h01, 1'b1},  // R5 R10 wait 0 rises
        {2'd0, 2'd2, 5'h01, 5'h00, 5'h01, 1'b0},  // R8 clear pending
        {2'd1, 2'd0, 5'h02, 5'h02, 5'h01, 1'b0},  // R7 masked wait 1
        {2'd0, 2'd0, 5'h02, 5'h02, 5'h03, 1'b1},  // R2 R10 enable wait 1
        {2'd0, 2'd1, 5'h02, 5'h02, 5'h01, 1'b0},  // R3 disable wait 1
        {2'd0, 2'd0, 5'h00, 5'h02, 5'h01, 1'b0},  // R2 zeros ignored
        {2'd0, 2'd1, 5'h00, 5'h02, 5'h01, 1'b0},  // R3 zeros ignored
        {2'd2, 2'd0, 5'h00, 5'h12, 5'h01, 1'b0},  // R6 R7 timeout masked
        {2'd0, 2'd0, 5'h10, 5'h12, 5'h11, 1'b1},  // R2 enable timeout
        {2'd0, 2'd2, 5'h12, 5'h00, 5'h11, 1'b0},  // R8 clear two bits
        {2'd0, 2'd2, 5'h00, 5'h00, 5'h11, 1'b0}   // R8 zeros ignored
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    logic [W-1:0] rv;

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state.
        rd(2'd2, rv); check("R1 pending", rv, '0);
        rd(2'd0, rv); check("R1 mask", rv, '0);
        check("R1 irq", W'(irq), '0);

        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            case (v[19:18])
                2'd0: wr(v[17:16], v[15:11]);
                2'd1: begin
                    @(negedge clk); wait_in = v[14:11];
                    repeat (4) @(negedge clk);
                    wait_in = '0;
                    repeat (4) @(negedge clk);
                end
                default: begin
                    @(negedge clk); tmo_pulse = 1'b1;
                    @(negedge clk); tmo_pulse = 1'b0;
                end
            endcase
            rd(2'd2, rv); check($sformatf("R8 vec%0d pending", i), rv, v[10:6]);
            rd(2'd0, rv); check($sformatf("R2 R3 vec%0d mask", i), rv, v[5:1]);
            check($sformatf("R10 vec%0d irq", i), W'(irq), W'(v[0]));
        end

        // R4: the clear address reads back the mask too.
        rd(2'd1, rv); check("R4 mask via clear address", rv, 5'h11);
        // R11: unused address reads zero.
        rd(2'd3, rv); check("R11 unused address", rv, '0);

        // R5: exact three-edge latency on wait 2.
        @(negedge clk); wait_in[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(2'd2, rv); check("R5 not yet after two edges", rv, '0);
        @(negedge clk);
        rd(2'd2, rv); check("R5 set on third edge", rv, 5'h04);
        // R5: a held level does not re-set the bit after a clear.
        wr(2'd2, 5'h04);
        repeat (5) @(negedge clk);
        rd(2'd2, rv); check("R5 held level no retrigger", rv, '0);
        wait_in = '0;
        repeat (4) @(negedge clk);

        // R9: a timeout and a status clear in the same cycle.
        tmo_pulse = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 5'h10;
        @(negedge clk);
        tmo_pulse = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd2, rv); check("R9 event beats clear", rv, 5'h10);
        check("R10 irq with timeout enabled", W'(irq), W'(1'b1));

        // R6: timing of a timeout pulse, one edge.
        wr(2'd2, 5'h10);
        tmo_pulse = 1'b1;
        @(negedge clk);
        tmo_pulse = 1'b0;
        rd(2'd2, rv); check("R6 one edge after pulse", rv, 5'h10);

        // R1: reset in mid-run empties state.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd2, rv); check("R1 pending after reset", rv, '0);
        rd(2'd0, rv); check("R1 mask after reset", rv, '0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule